// File: doc/BRIEF.md
# CSR Access Gate and Read-Modify-Write Unit

This block is the combinational front end that executes control-and-status-register instructions in a processor pipeline. A request gives a 12-bit register address, one of four operation codes, an operand and the current privilege level. The unit decides whether the access is legal and turns the operation into a value/mask pair. It returns the old register contents and, for a legal access that modifies the register, raises a write strobe with the merged data for the register bank.

The legality decision uses the address bits: a privilege floor and a read-only marker. It also applies three special rules. A block of user-visible counters is gated bit by bit through counter-enable vectors. Supervisor-level registers are refused when supervisor mode is absent. The address-translation register is refused to supervisor code while a trap-on-translation status bit is set. The register bank itself is outside this block. It reports, for the presented address, whether a register exists there and what it holds.

Top module: `csr_access_unit`

## Requirements
- R1: The minimum privilege of a register is address bits [9:8] (U=0, S=1, M=3); a request from a lower current privilege is illegal.
- R2: A register whose address bits [11:10] are 2'b11 is read-only; a request to it with a nonzero write mask is illegal, while a zero-mask request (read, or set/clear with a zero operand) is legal.
- R3: The merged write data equals (old & ~mask) | (value & mask), bit by bit.
- R4: Operation codes: 2'b00 read (mask zero); 2'b01 write (value = operand, mask all ones); 2'b10 set (value all ones, mask = operand); 2'b11 clear (value zero, mask = operand).
- R5: A legal request with a zero mask raises no write strobe; a legal request returns the bank's read data as the old value, and an illegal one returns zero.
- R6: Addresses 0xC00 to 0xC1F are counters gated by enable bit index address[4:0]: in U mode by the supervisor-granted vector, in S mode by the machine-granted vector, and always allowed in M mode.
- R7: A register with address bits [9:8] equal to 1 is illegal when supervisor mode is not implemented, whatever the current privilege.
- R8: A request to an address for which the bank reports no register is illegal.
- R9: A request to address 0x180 from S mode is illegal while the translation-trap bit is set; M mode is unaffected by that bit.
- R10: All outputs follow the request in the same cycle; the write strobe is never raised together with the illegal flag; with no valid request, illegal, strobe and old value are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the embedded checks |
| rst_n | input | 1 | Active-low reset for the embedded checks |
| req_valid | input | 1 | A register instruction is presented this cycle |
| req_addr | input | 12 | Register address |
| req_op | input | 2 | Operation code (R4) |
| req_operand | input | XLEN | Source operand |
| cur_priv | input | 2 | Current privilege level |
| s_grant_en | input | 32 | Counter enables granted by the supervisor, checked in U mode |
| m_grant_en | input | 32 | Counter enables granted by the machine level, checked in S mode |
| has_smode | input | 1 | Supervisor mode is implemented |
| xlat_trap | input | 1 | Trap supervisor accesses to the translation register |
| bank_hit | input | 1 | The bank holds a register at req_addr |
| bank_rdata | input | XLEN | Current contents of the register at req_addr |
| old_value | output | XLEN | Value returned to the destination register |
| illegal | output | 1 | Illegal-instruction flag |
| wr_en | output | 1 | Write strobe to the bank |
| wr_data | output | XLEN | Merged data to write |

## Verification
The hardest cases to reach are the zero-mask accesses to read-only registers. A set or clear whose operand is zero must succeed without a strobe. A nonzero operand on the same address must fault. The bench hits this on purpose with directed set and clear requests of zero and nonzero operands on a read-only address. A second hard case is the counter gate, where the enable vector that applies changes with the privilege. The bench sets the user-side and machine-side vectors to opposite values so that each mode has its own outcome. A randomized phase then mixes addresses, operations, privileges and side flags, and a behavioural model in the bench predicts every output.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;

   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_WRITE = 2'b01,
      OP_SET   = 2'b10,
      OP_CLEAR = 2'b11
   } csr_op_e;

   typedef enum logic [1:0] {
      PRIV_U   = 2'b00,
      PRIV_S   = 2'b01,
      PRIV_RSV = 2'b10,
      PRIV_M   = 2'b11
   } priv_e;

   // Field positions that neighbouring logic depends on
   localparam int PRIV_FIELD_LSB = 8;
   localparam int RO_FIELD_LSB   = 10;

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
   import csr_gate_pkg::*;
#(
   parameter int               ADDR_W    = 12,
   parameter int               CNT_IDX_W = 5,
   parameter logic [ADDR_W-1:0] CNT_BASE  = 12'hC00,
   parameter logic [ADDR_W-1:0] XLAT_ADDR = 12'h180
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [1:0]           min_priv,
   output logic                 ro,
   output logic                 is_cnt,
   output logic                 is_super,
   output logic                 is_xlat,
   output logic [CNT_IDX_W-1:0] cnt_idx
);

   localparam int CNT_TAG_W = ADDR_W - CNT_IDX_W;

   if (ADDR_W != 12) begin : g_bad_addr_w
      $error("csr_addr_decode: ADDR_W must be 12");
   end
   if (CNT_BASE[CNT_IDX_W-1:0] != '0) begin : g_bad_cnt_base
      $error("csr_addr_decode: CNT_BASE must be aligned to the counter span");
   end

   logic [CNT_TAG_W-1:0] cnt_tag;

   always_comb begin
      min_priv = addr[PRIV_FIELD_LSB +: 2];
      ro       = (addr[RO_FIELD_LSB +: 2] == 2'b11);
      is_super = (addr[PRIV_FIELD_LSB +: 2] == PRIV_S);
      is_xlat  = (addr == XLAT_ADDR);
      cnt_tag  = CNT_BASE[ADDR_W-1:CNT_IDX_W];
      is_cnt   = (addr[ADDR_W-1:CNT_IDX_W] == cnt_tag);
      cnt_idx  = addr[CNT_IDX_W-1:0];
   end

endmodule

// File: rtl/csr_perm_check.sv
module csr_perm_check
   import csr_gate_pkg::*;
#(
   parameter int CNT_IDX_W     = 5,
   parameter bit GATE_COUNTERS = 1'b1,
   localparam int CNT_N        = 2 ** CNT_IDX_W
) (
   input  logic [1:0]           cur_priv,
   input  logic [1:0]           min_priv,
   input  logic                 ro,
   input  logic                 is_cnt,
   input  logic                 is_super,
   input  logic                 is_xlat,
   input  logic [CNT_IDX_W-1:0] cnt_idx,
   input  logic [CNT_N-1:0]     s_grant_en,
   input  logic [CNT_N-1:0]     m_grant_en,
   input  logic                 has_smode,
   input  logic                 xlat_trap,
   input  logic                 bank_hit,
   input  logic                 mask_nz,
   output logic                 fault
);

   logic cnt_block;

   if (GATE_COUNTERS) begin : g_cnt_gate
      always_comb begin
         unique case (cur_priv)
            PRIV_U:  cnt_block = is_cnt & ~s_grant_en[cnt_idx];
            PRIV_S:  cnt_block = is_cnt & ~m_grant_en[cnt_idx];
            default: cnt_block = 1'b0;
         endcase
      end
   end else begin : g_cnt_open
      assign cnt_block = 1'b0;
   end

   logic too_low, ro_write, no_super, xlat_block;

   always_comb begin
      too_low    = (cur_priv < min_priv);
      ro_write   = ro & mask_nz;
      no_super   = is_super & ~has_smode;
      xlat_block = is_xlat & (cur_priv == PRIV_S) & xlat_trap;
      fault      = ~bank_hit | too_low | ro_write | no_super | xlat_block | cnt_block;
   end

endmodule

// File: rtl/csr_rmw_merge.sv
module csr_rmw_merge
   import csr_gate_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [1:0]      op,
   input  logic [XLEN-1:0] operand,
   input  logic [XLEN-1:0] old,
   output logic [XLEN-1:0] wdata,
   output logic            mask_nz
);

   logic [XLEN-1:0] mask, value;

   always_comb begin
      unique case (csr_op_e'(op))
         OP_WRITE: begin value = operand; mask = '1;      end
         OP_SET:   begin value = '1;      mask = operand; end
         OP_CLEAR: begin value = '0;      mask = operand; end
         default:  begin value = '0;      mask = '0;      end
      endcase
      mask_nz = |mask;
   end

   for (genvar b = 0; b < XLEN; b++) begin : g_bit
      assign wdata[b] = mask[b] ? value[b] : old[b];
   end

endmodule

// File: rtl/csr_access_unit.sv
module csr_access_unit
   import csr_gate_pkg::*;
#(
   parameter int               XLEN          = 32,
   parameter int               ADDR_W        = 12,
   parameter int               CNT_IDX_W     = 5,
   parameter logic [ADDR_W-1:0] CNT_BASE      = 12'hC00,
   parameter logic [ADDR_W-1:0] XLAT_ADDR     = 12'h180,
   parameter bit               GATE_COUNTERS = 1'b1,
   localparam int              CNT_N         = 2 ** CNT_IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_op,
   input  logic [XLEN-1:0]   req_operand,
   input  logic [1:0]        cur_priv,
   input  logic [CNT_N-1:0]  s_grant_en,
   input  logic [CNT_N-1:0]  m_grant_en,
   input  logic              has_smode,
   input  logic              xlat_trap,
   input  logic              bank_hit,
   input  logic [XLEN-1:0]   bank_rdata,
   output logic [XLEN-1:0]   old_value,
   output logic              illegal,
   output logic              wr_en,
   output logic [XLEN-1:0]   wr_data
);

   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("csr_access_unit: XLEN must be 32 or 64");
   end

   logic [1:0]           min_priv;
   logic                 ro, is_cnt, is_super, is_xlat;
   logic [CNT_IDX_W-1:0] cnt_idx;
   logic                 mask_nz, fault, grant;

   csr_addr_decode #(
      .ADDR_W(ADDR_W), .CNT_IDX_W(CNT_IDX_W),
      .CNT_BASE(CNT_BASE), .XLAT_ADDR(XLAT_ADDR)
   ) decode_i (
      .addr(req_addr), .min_priv(min_priv), .ro(ro), .is_cnt(is_cnt),
      .is_super(is_super), .is_xlat(is_xlat), .cnt_idx(cnt_idx)
   );

   csr_rmw_merge #(.XLEN(XLEN)) merge_i (
      .op(req_op), .operand(req_operand), .old(bank_rdata),
      .wdata(wr_data), .mask_nz(mask_nz)
   );

   csr_perm_check #(
      .CNT_IDX_W(CNT_IDX_W), .GATE_COUNTERS(GATE_COUNTERS)
   ) perm_i (
      .cur_priv(cur_priv), .min_priv(min_priv), .ro(ro), .is_cnt(is_cnt),
      .is_super(is_super), .is_xlat(is_xlat), .cnt_idx(cnt_idx),
      .s_grant_en(s_grant_en), .m_grant_en(m_grant_en),
      .has_smode(has_smode), .xlat_trap(xlat_trap), .bank_hit(bank_hit),
      .mask_nz(mask_nz), .fault(fault)
   );

   always_comb begin
      grant     = req_valid & ~fault;
      illegal   = req_valid & fault;
      wr_en     = grant & mask_nz;
      old_value = grant ? bank_rdata : '0;
   end

   AST_PRIV_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (cur_priv < req_addr[9:8]) |-> illegal); // R1
   AST_RO_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_addr[11:10] == 2'b11) |-> !wr_en); // R2
   AST_SET_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (req_op == OP_SET) |-> ((wr_data & bank_rdata) == bank_rdata)); // R3
   AST_WRITE_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (req_op == OP_WRITE) |-> (wr_data == req_operand)); // R4
   AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && (req_op == OP_READ) |-> !wr_en); // R5
   AST_OK_RETURNS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !illegal |-> (old_value == bank_rdata)); // R5
   AST_NO_SUPER: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !has_smode && (req_addr[9:8] == 2'b01) |-> illegal); // R7
   AST_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !bank_hit |-> illegal); // R8
   AST_FAULT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !wr_en); // R10
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!illegal && !wr_en && (old_value == '0))); // R10

endmodule

// File: tb/csr_access_unit_tb_top.sv
`timescale 1ns/1ps
module csr_access_unit_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [11:0] req_addr = '0;
   logic [1:0]  req_op = '0;
   logic [31:0] req_operand = '0;
   logic [1:0]  cur_priv = 2'b11;
   logic [31:0] s_grant_en = '0;
   logic [31:0] m_grant_en = '0;
   logic        has_smode = 1'b1;
   logic        xlat_trap = 1'b0;
   logic        bank_hit;
   logic [31:0] bank_rdata;
   logic [31:0] old_value, wr_data;
   logic        illegal, wr_en;

   int nchk = 0;
   int nfail = 0;
   bit done = 0;

   logic [31:0] mem [0:7];

   always #2.5 clk = ~clk;

   csr_access_unit dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_op(req_op), .req_operand(req_operand), .cur_priv(cur_priv),
      .s_grant_en(s_grant_en), .m_grant_en(m_grant_en), .has_smode(has_smode),
      .xlat_trap(xlat_trap), .bank_hit(bank_hit), .bank_rdata(bank_rdata),
      .old_value(old_value), .illegal(illegal), .wr_en(wr_en), .wr_data(wr_data)
   );

   // Stub register bank
   function automatic int bank_idx(logic [11:0] a);
      case (a)
         12'h001: return 0;
         12'h100: return 1;
         12'h180: return 2;
         12'h300: return 3;
         12'h340: return 4;
         12'hF14: return 5;
         12'h7C0: return 6;
         default: return (a[11:5] == 7'h60) ? 7 : -1;
      endcase
   endfunction

   function automatic logic [31:0] bank_val(logic [11:0] a);
      int i = bank_idx(a);
      if (i < 0) return 32'hDEAD_BEEF;
      if (i == 7) return mem[7] + 32'(a[4:0]);
      return mem[i];
   endfunction

   always_comb begin
      bank_hit   = (bank_idx(req_addr) >= 0);
      bank_rdata = bank_val(req_addr);
   end

   always @(posedge clk) begin
      if (wr_en && bank_idx(req_addr) >= 0) mem[bank_idx(req_addr)] <= wr_data;
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive one request and compare the DUT with a behavioural model
   task automatic do_req(string tag, logic v, logic [11:0] a, logic [1:0] op,
                         logic [31:0] opnd, logic [1:0] pr);
      logic [31:0] val, msk, old, merged;
      logic        hit, ill, exp_wr;
      @(negedge clk);
      req_valid = v; req_addr = a; req_op = op; req_operand = opnd; cur_priv = pr;
      #1;
      case (op)
         2'b01:   begin val = opnd;  msk = '1;   end
         2'b10:   begin val = '1;    msk = opnd; end
         2'b11:   begin val = '0;    msk = opnd; end
         default: begin val = '0;    msk = '0;   end
      endcase
      hit = (bank_idx(a) >= 0);
      old = bank_val(a);
      ill = !hit;
      if (pr < a[9:8]) ill = 1;
      if (a[11:10] == 2'b11 && msk != 0) ill = 1;
      if (a[9:8] == 2'b01 && !has_smode) ill = 1;
      if (a == 12'h180 && pr == 2'b01 && xlat_trap) ill = 1;
      if (a >= 12'hC00 && a <= 12'hC1F) begin
         if (pr == 2'b00 && !s_grant_en[a[4:0]]) ill = 1;
         if (pr == 2'b01 && !m_grant_en[a[4:0]]) ill = 1;
      end
      merged = (old & ~msk) | (val & msk);
      if (!v) ill = 0;
      exp_wr = v && !ill && (msk != 0);
      chk(tag, 32'(illegal), 32'(ill));
      chk("R5", old_value, (v && !ill) ? old : 32'h0);
      chk("R5", 32'(wr_en), 32'(exp_wr));
      if (exp_wr) chk("R3", wr_data, merged);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) mem[i] = 32'h1000_0000 * i + 32'h55;
      repeat (3) @(negedge clk);
      #1;
      chk("R10", 32'(illegal), 32'h0);
      chk("R10", 32'(wr_en), 32'h0);
      chk("R10", old_value, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R4 / R3: each operation on a machine register
      do_req("R4", 1, 12'h300, 2'b01, 32'hA5A5_0F0F, 2'b11);
      do_req("R4", 1, 12'h300, 2'b10, 32'h0000_00F0, 2'b11);
      do_req("R4", 1, 12'h300, 2'b11, 32'hA000_000F, 2'b11);
      do_req("R4", 1, 12'h300, 2'b00, 32'hFFFF_FFFF, 2'b11);
      // R2: read-only register
      do_req("R2", 1, 12'hF14, 2'b01, 32'h1234_5678, 2'b11);
      do_req("R2", 1, 12'hF14, 2'b00, 32'h0, 2'b11);
      do_req("R2", 1, 12'hF14, 2'b10, 32'h0, 2'b11);
      do_req("R2", 1, 12'hF14, 2'b11, 32'h0000_0001, 2'b11);
      // R1: privilege floor
      do_req("R1", 1, 12'h300, 2'b00, 32'h0, 2'b00);
      do_req("R1", 1, 12'h300, 2'b01, 32'h7, 2'b01);
      do_req("R1", 1, 12'h100, 2'b01, 32'h0000_0022, 2'b01);
      do_req("R1", 1, 12'h100, 2'b00, 32'h0, 2'b00);
      do_req("R1", 1, 12'h001, 2'b10, 32'h0000_0100, 2'b00);
      // R7: no supervisor mode
      has_smode = 1'b0;
      do_req("R7", 1, 12'h100, 2'b00, 32'h0, 2'b11);
      do_req("R7", 1, 12'h180, 2'b01, 32'h3, 2'b11);
      has_smode = 1'b1;
      // R9: translation trap
      xlat_trap = 1'b1;
      do_req("R9", 1, 12'h180, 2'b00, 32'h0, 2'b01);
      do_req("R9", 1, 12'h180, 2'b01, 32'h8000_0001, 2'b11);
      xlat_trap = 1'b0;
      do_req("R9", 1, 12'h180, 2'b01, 32'h8000_0002, 2'b01);
      // R6: counter gating, opposite vectors per mode
      s_grant_en = 32'h0000_0004;
      m_grant_en = 32'hFFFF_FFFB;
      do_req("R6", 1, 12'hC02, 2'b00, 32'h0, 2'b00);
      do_req("R6", 1, 12'hC02, 2'b00, 32'h0, 2'b01);
      do_req("R6", 1, 12'hC03, 2'b00, 32'h0, 2'b00);
      do_req("R6", 1, 12'hC03, 2'b00, 32'h0, 2'b01);
      do_req("R6", 1, 12'hC02, 2'b00, 32'h0, 2'b11);
      do_req("R6", 1, 12'hC1F, 2'b10, 32'h0, 2'b01);
      // R8: unmapped address
      do_req("R8", 1, 12'h555, 2'b00, 32'h0, 2'b11);
      do_req("R8", 1, 12'hC20, 2'b00, 32'h0, 2'b11);
      // R10: idle cycle with a write operation presented
      do_req("R10", 0, 12'h300, 2'b01, 32'hFFFF_0000, 2'b11);

      // Randomized mix against the model
      for (int k = 0; k < 400; k++) begin
         logic [11:0] al [12] = '{12'h001, 12'h100, 12'h180, 12'h300, 12'h340,
                                  12'hF14, 12'h7C0, 12'hC00, 12'hC05, 12'hC1F,
                                  12'h555, 12'hB00};
         logic [1:0]  pl [3] = '{2'b00, 2'b01, 2'b11};
         s_grant_en = $urandom;
         m_grant_en = $urandom;
         has_smode  = ($urandom % 4) != 0;
         xlat_trap  = $urandom % 2;
         do_req("R1", ($urandom % 8) != 0, al[$urandom % 12], 2'($urandom),
                (($urandom % 5) == 0) ? 32'h0 : 32'($urandom), pl[$urandom % 3]);
      end

      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

endmodule